// File: doc/BRIEF.md
# Stack Push/Pull Instruction Sequencer

This block carries out the one-byte stack instructions of an 8-bit accumulator processor, one bus cycle at a time. It saves and restores the accumulator, the status byte and the two index registers. It owns those registers and the 8-bit stack pointer. Each access reaches a synchronous memory bus that performs one read or one write per cycle. Read data must be valid before the clock edge that ends the read cycle.

A `start` strobe marks the opcode fetch cycle and carries the fetched `opcode` and the address of the following program byte. A push then uses two more cycles and a pull uses three. `done` is raised in the last of them, and the register update takes effect at the clock edge that ends that cycle. The `ext_mode` input selects the extended instruction set. Only in that mode are the index-register push and pull opcodes accepted. In the base set they are reported as illegal.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer equals `SP_INIT` (0xFD), A, X, Y and P are 0x00, and `bus_rd`, `bus_wr`, `done` and `illegal` are low.
- R2: Every stack access (the discarded stack read, the pulling read and the push write) uses address {0x01, stack pointer}. The bus never reads and writes in the same cycle.
- R3: A push reads `pc_addr` in the cycle after `start`, then writes the register to {0x01, SP} with `done` high in the next cycle. The stack pointer decrements once, at the end of the write cycle.
- R4: A pull reads `pc_addr` in the cycle after `start`, then reads {0x01, SP} and discards the byte. In the third cycle it reads {0x01, SP+1} with `done` high and loads that byte into the target. The stack pointer ends up incremented by one.
- R5: Pulling into A, X or Y sets P bit 7 (negative) to bit 7 of the byte and P bit 1 (zero) to whether the byte is 0x00. All other P bits keep their values.
- R6: Pushing the status byte writes P with bit 4 forced to 1. Pulling the status byte loads all eight P bits from the stack byte.
- R7: In both modes 0x48 pushes A, 0x68 pulls A, 0x08 pushes P and 0x28 pulls P. With `ext_mode`=1, 0xDA pushes X, 0x5A pushes Y, 0xFA pulls X and 0x7A pulls Y.
- R8: The cycle after `start` with an unrecognised opcode raises `done` and `illegal` together. In that cycle there is no bus access, and no register or the stack pointer changes. With `ext_mode`=0 this applies to 0x5A, 0xDA, 0x7A and 0xFA.
- R9: The stack pointer wraps modulo 256. A pull at 0xFF reads 0x1FF and then 0x100, and a push at 0x00 writes 0x100 and leaves 0xFF.
- R10: A `start` pulse while an instruction is in progress is ignored. The running instruction's bus cycles and results are unchanged, and no extra instruction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects the extended opcode set, sampled with `start` |
| start | input | 1 | Opcode fetch cycle strobe |
| opcode | input | 8 | Fetched opcode, valid with `start` |
| pc_addr | input | 16 | Address of the next program byte, valid with `start` |
| bus_addr | output | 16 | Memory address |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid before the edge ending a read cycle |
| done | output | 1 | Last cycle of the instruction |
| illegal | output | 1 | Opcode was not recognised |
| a_out | output | 8 | Accumulator |
| x_out | output | 8 | X index register |
| y_out | output | 8 | Y index register |
| sp_out | output | 8 | Stack pointer |
| p_out | output | 8 | Status byte |

## Verification
The bench drives the stack pointer across both wrap points. If the pointer is extended or saturated instead of wrapped, the next access lands outside page one or repeats an address. It pulls 0x00 and a byte with bit 7 set, so that a swapped or missing zero or negative update shows up in P. It also pushes the status byte, which exposes a missing break-bit force or one that leaks back into the register. The index opcodes are issued in base mode, where a design that decodes them anyway would put bus traffic in a cycle that must stay silent. A start pulse arrives mid-instruction, and a design that accepts it would break the expected bus sequence.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0] SP_INIT    = 8'hFD,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] pc_addr,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        done,
  output logic        illegal,
  output logic [7:0]  a_out,
  output logic [7:0]  x_out,
  output logic [7:0]  y_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  p_out
);

  typedef enum logic [2:0] {S_IDLE, S_PCRD, S_SDUM, S_PULL, S_PUSH, S_BAD} st_t;
  typedef enum logic [1:0] {T_A, T_X, T_Y, T_P} tg_t;

  st_t         st;
  tg_t         tgt, dec_tgt;
  logic        pull_q, dec_pull, dec_ok;
  logic [15:0] pc_q;
  logic [7:0]  a_r, x_r, y_r, sp_r, p_r;

  always_comb begin
    dec_ok   = 1'b1;
    dec_pull = 1'b0;
    dec_tgt  = T_A;
    case (opcode)
      8'h48: dec_tgt = T_A;
      8'h68: begin dec_tgt = T_A; dec_pull = 1'b1; end
      8'h08: dec_tgt = T_P;
      8'h28: begin dec_tgt = T_P; dec_pull = 1'b1; end
      8'hDA: begin dec_tgt = T_X; dec_ok = ext_mode; end
      8'h5A: begin dec_tgt = T_Y; dec_ok = ext_mode; end
      8'hFA: begin dec_tgt = T_X; dec_pull = 1'b1; dec_ok = ext_mode; end
      8'h7A: begin dec_tgt = T_Y; dec_pull = 1'b1; dec_ok = ext_mode; end
      default: dec_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tgt    <= T_A;
      pull_q <= 1'b0;
      pc_q   <= 16'h0000;
      a_r    <= 8'h00;
      x_r    <= 8'h00;
      y_r    <= 8'h00;
      sp_r   <= SP_INIT;
      p_r    <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pc_q   <= pc_addr;
          tgt    <= dec_tgt;
          pull_q <= dec_pull;
          st     <= dec_ok ? S_PCRD : S_BAD;
        end
        S_PCRD: st <= pull_q ? S_SDUM : S_PUSH;
        S_SDUM: begin
          sp_r <= sp_r + 8'd1;
          st   <= S_PULL;
        end
        S_PULL: begin
          case (tgt)
            T_A: a_r <= bus_rdata;
            T_X: x_r <= bus_rdata;
            T_Y: y_r <= bus_rdata;
            default: p_r <= bus_rdata;
          endcase
          if (tgt != T_P) begin
            p_r[7] <= bus_rdata[7];
            p_r[1] <= (bus_rdata == 8'h00);
          end
          st <= S_IDLE;
        end
        S_PUSH: begin
          sp_r <= sp_r - 8'd1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_rd   = (st == S_PCRD) || (st == S_SDUM) || (st == S_PULL);
  assign bus_wr   = (st == S_PUSH);
  assign bus_addr = (st == S_PCRD) ? pc_q :
                    (bus_rd || bus_wr) ? {STACK_PAGE, sp_r} : 16'h0000;
  assign done     = (st == S_PULL) || (st == S_PUSH) || (st == S_BAD);
  assign illegal  = (st == S_BAD);

  always_comb begin
    bus_wdata = 8'h00;
    if (bus_wr) begin
      case (tgt)
        T_A: bus_wdata = a_r;
        T_X: bus_wdata = x_r;
        T_Y: bus_wdata = y_r;
        default: bus_wdata = p_r | 8'h10;
      endcase
    end
  end

  assign a_out  = a_r;
  assign x_out  = x_r;
  assign y_out  = y_r;
  assign sp_out = sp_r;
  assign p_out  = p_r;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R2
  AST_FINAL_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> bus_addr[15:8] == STACK_PAGE); // R2
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> sp_out == $past(sp_out) - 8'd1); // R3
  AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_rd) |=> sp_out == $past(sp_out)); // R4
  AST_NZ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_rd && tgt != T_P) |=>
      (p_out[1] == ($past(bus_rdata) == 8'h00)) && (p_out[7] == $past(bus_rdata[7]))); // R5
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!bus_rd && !bus_wr && done)); // R8
  AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(sp_out) && $stable(a_out) && $stable(p_out)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc_addr = 16'h0000;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, done, illegal;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  a_out, x_out, y_out, sp_out, p_out;

  logic [7:0]  mem [65536];
  logic [31:0] expq [$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [7:0]  ea = 8'h00, ex = 8'h00, ey = 8'h00, esp = 8'hFD, ep = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .start(start),
    .opcode(opcode), .pc_addr(pc_addr), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .illegal(illegal),
    .a_out(a_out), .x_out(x_out), .y_out(y_out), .sp_out(sp_out), .p_out(p_out)
  );

  assign bus_rdata = mem[bus_addr];
  always @(posedge clk) if (bus_wr) mem[bus_addr] <= bus_wdata;

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] item(bit rd, bit wr, bit dn, bit il, logic [15:0] ad, logic [7:0] dt);
    return {rd, wr, dn, il, 4'h0, ad, dt};
  endfunction

  // monitor: compares each bus cycle against the scoreboard queue
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [31:0] e, a;
        e = expq.pop_front();
        a = item(bus_rd, bus_wr, done, illegal,
                 (bus_rd || bus_wr) ? bus_addr : 16'h0, bus_wr ? bus_wdata : 8'h0);
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL R2/R3/R4/R8 bus cycle: actual %08h expected %08h", a, e);
        end
      end else if (bus_rd || bus_wr || done) begin
        n_chk++;
        n_fail++;
        $display("FAIL R10 stray bus cycle: actual rd%0b wr%0b done%0b expected idle",
                 bus_rd, bus_wr, done);
      end
    end
  end

  // driver: issues one opcode, queues the expected cycles, updates the model
  task automatic run_op(logic [7:0] op, bit ext, bit poke, string req);
    bit ok, pull;
    int tg;
    int ncyc;
    logic [7:0] v;
    logic [15:0] pc;
    pc = 16'h8000 + 16'(op);
    ok = 1; pull = 0; tg = 0;
    case (op)
      8'h48: tg = 0;
      8'h68: begin tg = 0; pull = 1; end
      8'h08: tg = 3;
      8'h28: begin tg = 3; pull = 1; end
      8'hDA: begin tg = 1; ok = ext; end
      8'h5A: begin tg = 2; ok = ext; end
      8'hFA: begin tg = 1; pull = 1; ok = ext; end
      8'h7A: begin tg = 2; pull = 1; ok = ext; end
      default: ok = 0;
    endcase
    @(negedge clk);
    opcode = op; ext_mode = ext; pc_addr = pc; start = 1'b1;
    if (!ok) begin
      expq.push_back(item(0, 0, 1, 1, 16'h0, 8'h0));
      ncyc = 1;
    end else if (!pull) begin
      v = (tg == 0) ? ea : (tg == 1) ? ex : (tg == 2) ? ey : (ep | 8'h10);
      expq.push_back(item(1, 0, 0, 0, pc, 8'h0));
      expq.push_back(item(0, 1, 1, 0, {8'h01, esp}, v));
      esp = esp - 8'd1;
      ncyc = 2;
    end else begin
      expq.push_back(item(1, 0, 0, 0, pc, 8'h0));
      expq.push_back(item(1, 0, 0, 0, {8'h01, esp}, 8'h0));
      esp = esp + 8'd1;
      v = mem[{8'h01, esp}];
      expq.push_back(item(1, 0, 1, 0, {8'h01, esp}, 8'h0));
      case (tg)
        0: ea = v;
        1: ex = v;
        2: ey = v;
        default: ep = v;
      endcase
      if (tg != 3) begin
        ep[7] = v[7];
        ep[1] = (v == 8'h00);
      end
      ncyc = 3;
    end
    @(negedge clk);
    if (poke) begin
      opcode = 8'h08; start = 1'b1;
      @(negedge clk);
      ncyc = ncyc - 1;
    end
    start = 1'b0;
    repeat (ncyc) @(negedge clk);
    check8({req, " A"},  a_out,  ea);
    check8({req, " X"},  x_out,  ex);
    check8({req, " Y"},  y_out,  ey);
    check8({req, " SP"}, sp_out, esp);
    check8({req, " P"},  p_out,  ep);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
    mem[16'h01FE] = 8'h00;
    mem[16'h01FF] = 8'h9C;
    mem[16'h0100] = 8'h41;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 SP", sp_out, 8'hFD);
    check8("R1 A", a_out, 8'h00);
    check8("R1 P", p_out, 8'h00);
    check8("R1 bus", {4'h0, bus_rd, bus_wr, done, illegal}, 8'h00);
    rst_n = 1'b1;
    run_op(8'h68, 1, 0, "R4 R5 PLA zero");
    run_op(8'hFA, 1, 0, "R7 R5 PLX negative");
    run_op(8'h7A, 1, 0, "R9 PLY wrap to 00");
    run_op(8'hDA, 1, 0, "R9 R7 PHX wrap to FF");
    run_op(8'h5A, 1, 0, "R3 PHY");
    run_op(8'h48, 1, 0, "R3 PHA");
    run_op(8'h08, 1, 0, "R6 PHP break forced");
    run_op(8'h28, 1, 0, "R6 PLP");
    run_op(8'hFA, 0, 0, "R8 base PLX illegal");
    run_op(8'h5A, 0, 0, "R8 base PHY illegal");
    run_op(8'hDA, 0, 0, "R8 base PHX illegal");
    run_op(8'h7A, 0, 0, "R8 base PLY illegal");
    run_op(8'h48, 0, 0, "R7 base PHA");
    run_op(8'h68, 0, 0, "R7 base PLA");
    run_op(8'hEA, 1, 0, "R8 unknown opcode");
    run_op(8'h68, 1, 1, "R10 start while busy");
    run_op(8'h48, 1, 1, "R10 start during push");
    repeat (4) @(negedge clk);
    // R10 nothing left pending
    check8("R10 queue empty", 8'(expq.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule